// File: doc/BRIEF.md
# Serial Programming Command Shifter

This block is the host end of a two-wire programming link. It owns a clock output and a data line with separate output, output-enable and input pins, so a pad cell can join them into one bidirectional wire. Each transaction is one frame: a 4-bit command code followed by a 16-bit operand, both sent least-significant bit first. A write frame clocks out all 20 bits. A read frame clocks out the command and the first 8 operand bits. It then releases the data line, holds the clock low for a turnaround delay, and clocks in 8 bits from the target.

The caller places the command, the operand and the read flag on the inputs and pulses `start` for one cycle. `busy` stays high for the whole frame. `done` pulses for one cycle at the end, and on a read frame `rd_byte` holds the received byte in that same cycle. The clock high time, the clock low time and the turnaround length are counted in system clocks. They come from run-time inputs, and their values are latched when the frame is accepted.

Top module: `serprog_host`

## Requirements
- R1: After reset the block is idle: `sclk` = 0, `sdat_oe` = 1, `busy` = 0, `done` = 0 and `rd_byte` = 0.
- R2: A frame sends `cmd_code[0..3]` and then `operand[0..15]`, one bit per clock period, least-significant bit first. The host changes `sdat_o` only in the cycle in which `sclk` rises, so each bit is stable at the falling edge of its clock.
- R3: `sclk` is high for `max(1,tck_high)` cycles and low for `max(1,tck_low)` cycles in each bit period. These values are taken when `start` is accepted.
- R4: On a read frame, `sdat_oe` drops in the cycle of the falling edge of the 12th frame clock (the 8th operand clock). `sclk` then stays low for `max(1,tck_low) + turn_dly` cycles before the next rising edge.
- R5: On a read frame, the host samples `sdat_i` at each of the last 8 falling edges, least-significant bit first. `rd_byte` returns these 8 bits, which are the upper half of the 16-bit operand slot.
- R6: `sdat_oe` returns to 1 only in the cycle in which `done` is high. It stays low between the release and that cycle.
- R7: `busy` rises one cycle after `start` is accepted. `done` pulses for exactly one cycle, and `busy` drops in that same cycle. The frame takes 20·(H+L) cycles, plus `turn_dly` on a read, counted from acceptance to `done`.
- R8: `start` has no effect while `busy` is high: the frame in flight, its timing and its single `done` pulse are unchanged.
- R9: `rd_byte` changes only at the end of a read frame. A write frame leaves it as it was.
- R10: A read frame with `turn_dly` = 0 adds no cycles: the first read clock rises right after the low phase of the 12th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| cmd_code | input | 4 | Command code, sent first |
| operand | input | 16 | Operand, sent after the command |
| is_read | input | 1 | 1 = the upper operand byte is read from the target |
| tck_high | input | CW | Clock high time in cycles (0 acts as 1) |
| tck_low | input | CW | Clock low time in cycles (0 acts as 1) |
| turn_dly | input | CW | Extra clock-low cycles after the line is released |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_byte | output | 8 | Byte captured by the last read frame |
| sclk | output | 1 | Programming clock to the target |
| sdat_o | output | 1 | Data driven towards the target |
| sdat_oe | output | 1 | Host drives the data line when 1 |
| sdat_i | input | 1 | Data line as seen from the host |

## Verification
`start` is driven in the low half of a system clock, so the design accepts it at the next rising edge. `busy` is then due at the first sample after that edge. `done` and the read byte are due exactly 20·(H+L) samples later, plus `turn_dly` on a read frame. The bench counts samples from acceptance and checks that `done` appears at exactly that count and in no other cycle. It records the bits the target would see from `sclk` falling transitions and counts the clock-low samples between the release and the first read clock. Results are read one or more samples after `done`, so no check races an edge.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int unsigned CMD_BITS   = 4;
  localparam int unsigned OPND_BITS  = 16;
  localparam int unsigned RD_BITS    = 8;
  localparam int unsigned FRAME_BITS = CMD_BITS + OPND_BITS;
  // index of the last host-driven clock of a read frame
  localparam int unsigned RELEASE_IDX = FRAME_BITS - RD_BITS - 1;
  localparam int unsigned LAST_IDX    = FRAME_BITS - 1;
  localparam int unsigned IDX_W       = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2,
    ST_TURN = 2'd3
  } seq_state_e;

  // zero programmed as a phase length still yields one cycle
  function automatic int unsigned phase_cycles(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // total cycles from acceptance of start until done
  function automatic int unsigned frame_cycles(input int unsigned hi,
                                               input int unsigned lo,
                                               input int unsigned turn,
                                               input bit          rd);
    return FRAME_BITS * (phase_cycles(hi) + phase_cycles(lo)) + (rd ? turn : 0);
  endfunction

endpackage

// File: rtl/serprog_phase_timer.sv
module serprog_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  // len is at least one; the phase lasts len cycles including the load cycle's successor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/serprog_seq.sv
module serprog_seq
  import serprog_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic [CW-1:0]    tck_high,
  input  logic [CW-1:0]    tck_low,
  input  logic [CW-1:0]    turn_dly,
  input  logic             expire,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_len,
  output logic             ev_accept,
  output logic             ev_rise,
  output logic             ev_fall,
  output logic             ev_release,
  output logic             ev_sample,
  output logic             ev_finish,
  output logic             ev_commit,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             sdat_oe
);

  localparam logic [IDX_W-1:0] REL_I  = IDX_W'(RELEASE_IDX);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST_IDX);

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  seq_state_e       st_q, st_d;
  logic [CW-1:0]    hi_q, lo_q, tt_q;
  logic             rd_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, done_q, sclk_q, oe_q;
  logic             at_release;

  assign at_release = rd_q && (idx_q == REL_I);

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_len   = hi_q;
    ev_accept = 1'b0;
    ev_rise   = 1'b0;
    ev_fall   = 1'b0;
    ev_finish = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_HIGH;
          tmr_load  = 1'b1;
          tmr_len   = at_least_one(tck_high);
          ev_accept = 1'b1;
        end
      end
      ST_HIGH: begin
        if (expire) begin
          st_d     = ST_LOW;
          tmr_load = 1'b1;
          tmr_len  = lo_q;
          ev_fall  = 1'b1;
        end
      end
      ST_LOW: begin
        if (expire) begin
          if (idx_q == LAST_I) begin
            st_d      = ST_IDLE;
            ev_finish = 1'b1;
          end else if (at_release && (tt_q != '0)) begin
            st_d     = ST_TURN;
            tmr_load = 1'b1;
            tmr_len  = tt_q;
          end else begin
            st_d     = ST_HIGH;
            tmr_load = 1'b1;
            tmr_len  = hi_q;
            ev_rise  = 1'b1;
          end
        end
      end
      ST_TURN: begin
        if (expire) begin
          st_d     = ST_HIGH;
          tmr_load = 1'b1;
          tmr_len  = hi_q;
          ev_rise  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ev_release = ev_fall && at_release;
  assign ev_sample  = ev_fall && rd_q && (idx_q > REL_I);
  assign ev_commit  = ev_finish && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hi_q   <= CW'(1);
      lo_q   <= CW'(1);
      tt_q   <= '0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (ev_accept) begin
        hi_q   <= at_least_one(tck_high);
        lo_q   <= at_least_one(tck_low);
        tt_q   <= turn_dly;
        rd_q   <= is_read;
        idx_q  <= '0;
        busy_q <= 1'b1;
        sclk_q <= 1'b1;
      end
      if (ev_rise) begin
        idx_q  <= idx_q + IDX_W'(1);
        sclk_q <= 1'b1;
      end
      if (ev_fall) begin
        sclk_q <= 1'b0;
      end
      if (ev_release) begin
        oe_q <= 1'b0;
      end
      if (ev_finish) begin
        oe_q   <= 1'b1;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sclk    = sclk_q;
  assign sdat_oe = oe_q;

endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter
  import serprog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [CMD_BITS-1:0]  cmd_code,
  input  logic [OPND_BITS-1:0] operand,
  input  logic                 shift,
  input  logic                 sample,
  input  logic                 commit,
  input  logic                 sdat_i,
  output logic                 sdat_o,
  output logic [RD_BITS-1:0]   rd_byte
);

  logic [FRAME_BITS-1:0] tx_q;
  logic [RD_BITS-1:0]    rx_q;
  logic [RD_BITS-1:0]    rd_q;

  // transmit: command in the low bits so it leaves first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= {operand, cmd_code};
    end else if (shift) begin
      tx_q <= {1'b0, tx_q[FRAME_BITS-1:1]};
    end
  end

  // receive: first sampled bit ends up in bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {sdat_i, rx_q[RD_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (commit) begin
      rd_q <= rx_q;
    end
  end

  assign sdat_o  = tx_q[0];
  assign rd_byte = rd_q;

endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CMD_BITS-1:0]  cmd_code,
  input  logic [OPND_BITS-1:0] operand,
  input  logic                 is_read,
  input  logic [CW-1:0]        tck_high,
  input  logic [CW-1:0]        tck_low,
  input  logic [CW-1:0]        turn_dly,
  output logic                 busy,
  output logic                 done,
  output logic [RD_BITS-1:0]   rd_byte,
  output logic                 sclk,
  output logic                 sdat_o,
  output logic                 sdat_oe,
  input  logic                 sdat_i
);

  // named internal events, visible to the bound checker
  logic          tmr_load;
  logic [CW-1:0] tmr_len;
  logic          tmr_expire;
  logic          ev_accept;
  logic          ev_rise;
  logic          ev_fall;
  logic          ev_release;
  logic          ev_sample;
  logic          ev_finish;
  logic          ev_commit;

  serprog_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .len    (tmr_len),
    .expire (tmr_expire)
  );

  serprog_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_read    (is_read),
    .tck_high   (tck_high),
    .tck_low    (tck_low),
    .turn_dly   (turn_dly),
    .expire     (tmr_expire),
    .tmr_load   (tmr_load),
    .tmr_len    (tmr_len),
    .ev_accept  (ev_accept),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall),
    .ev_release (ev_release),
    .ev_sample  (ev_sample),
    .ev_finish  (ev_finish),
    .ev_commit  (ev_commit),
    .busy       (busy),
    .done       (done),
    .sclk       (sclk),
    .sdat_oe    (sdat_oe)
  );

  serprog_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .cmd_code (cmd_code),
    .operand  (operand),
    .shift    (ev_rise),
    .sample   (ev_sample),
    .commit   (ev_commit),
    .sdat_i   (sdat_i),
    .sdat_o   (sdat_o),
    .rd_byte  (rd_byte)
  );

endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk
  import serprog_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               is_read,
  input logic [CW-1:0]      tck_high,
  input logic [CW-1:0]      tck_low,
  input logic [CW-1:0]      turn_dly,
  input logic               busy,
  input logic               done,
  input logic [RD_BITS-1:0] rd_byte,
  input logic               sclk,
  input logic               sdat_o,
  input logic               sdat_oe,
  input logic               ev_fall
);

  logic          prev_busy, prev_rd;
  logic [CW-1:0] prev_h, prev_l, prev_t;
  int unsigned   hi_ref, exp_ref, hcnt, lat;
  int unsigned   hi_use;
  logic          first_busy;

  assign first_busy = busy && !prev_busy;
  assign hi_use     = first_busy ? phase_cycles(int'(prev_h)) : hi_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_busy <= 1'b0;
      prev_rd   <= 1'b0;
      prev_h    <= '0;
      prev_l    <= '0;
      prev_t    <= '0;
      hi_ref    <= 1;
      exp_ref   <= 0;
      hcnt      <= 0;
      lat       <= 0;
    end else begin
      prev_busy <= busy;
      prev_rd   <= is_read;
      prev_h    <= tck_high;
      prev_l    <= tck_low;
      prev_t    <= turn_dly;
      hcnt      <= sclk ? hcnt + 1 : 0;
      lat       <= busy ? lat + 1 : 0;
      if (first_busy) begin
        hi_ref  <= phase_cycles(int'(prev_h));
        exp_ref <= frame_cycles(int'(prev_h), int'(prev_l), int'(prev_t), prev_rd);
      end
    end
  end

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && $rose(sclk)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == exp_ref));

  assert_high_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |-> (hcnt + 1 == hi_use));

  assert_tx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdat_oe && !$rose(sclk)) |-> $stable(sdat_o));

  assert_release_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdat_oe) |-> (!sclk && busy));

  assert_oe_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> done);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_byte) |-> done);

endmodule

bind serprog_host serprog_host_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_serprog_host.sv
module sim_serprog_host;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    cmd_code = '0;
  logic [15:0]   operand = '0;
  logic          is_read = 1'b0;
  logic [CW-1:0] tck_high = 8'd1;
  logic [CW-1:0] tck_low = 8'd1;
  logic [CW-1:0] turn_dly = '0;
  logic          busy, done, sclk, sdat_o, sdat_oe;
  logic [7:0]    rd_byte;
  logic          sdat_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serprog_host #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
    .operand(operand), .is_read(is_read), .tck_high(tck_high),
    .tck_low(tck_low), .turn_dly(turn_dly), .busy(busy), .done(done),
    .rd_byte(rd_byte), .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
    .sdat_i(sdat_i)
  );

  // target model: logs host bits at falling clocks, answers after rising clocks
  logic [19:0] hlog;
  logic [7:0]  tbyte = '0;
  int fcnt = 0, rcnt = 0, gap = 0, dcnt = 0;
  logic ps = 1'b0, pb = 1'b0;

  always @(negedge clk) begin
    if (busy && !pb) begin
      fcnt = 0; rcnt = 0; gap = 0; dcnt = 0; hlog = '0;
    end
    if (ps && !sclk) begin
      if (fcnt < 20) hlog[fcnt] = sdat_o;
      fcnt++;
    end
    if (!ps && sclk && !sdat_oe) begin
      if (rcnt < 8) sdat_i = tbyte[rcnt];
      rcnt++;
    end
    if (busy && !sdat_oe && !sclk && rcnt == 0) gap++;
    if (done) dcnt++;
    ps = sclk;
    pb = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // one frame; returns cycles from acceptance to done
  task automatic run_txn(input string req, input logic [3:0] c, input logic [15:0] op,
                         input bit rd, input int h, input int l, input int t,
                         input logic [7:0] tb, input bit poke, output int lat,
                         output logic [7:0] rb_at_done);
    int k;
    @(negedge clk);
    cmd_code = c; operand = op; is_read = rd;
    tck_high = CW'(h); tck_low = CW'(l); turn_dly = CW'(t);
    tbyte = tb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    while (!done && k < 20000) begin
      if (poke && k == 5) begin
        start = 1'b1; cmd_code = ~c; operand = ~op; is_read = ~rd;
        tck_high = 8'd9; tck_low = 8'd9;
      end
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    lat = k - 1;
    rb_at_done = rd_byte;
    chk(busy == 1'b0, "R7", "busy low with done", busy, 0);
    chk(sdat_oe == 1'b1, "R6", "oe back at done", sdat_oe, 1);
    repeat (3) @(negedge clk);
    chk(dcnt == 1, req, "single done pulse", dcnt, 1);
  endtask

  task automatic t_reset;
    chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    chk(sdat_oe == 1'b1, "R1", "reset oe", sdat_oe, 1);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(rd_byte == 8'h00, "R1", "reset rd_byte", rd_byte, 0);
  endtask

  task automatic t_write(input logic [3:0] c, input logic [15:0] op, input int h, input int l);
    int lat; logic [7:0] rb; int n;
    n = 20 * (eff(h) + eff(l));
    run_txn("R7", c, op, 1'b0, h, l, 0, 8'h00, 1'b0, lat, rb);
    chk(lat == n, "R3", "write frame length", lat, n);
    chk(hlog == {op, c}, "R2", "bits seen by target", hlog, {op, c});
    chk(fcnt == 20, "R2", "clock count", fcnt, 20);
  endtask

  task automatic t_read(input logic [15:0] op, input int h, input int l, input int t,
                        input logic [7:0] tb, input string treq);
    int lat; logic [7:0] rb; int n;
    n = 20 * (eff(h) + eff(l)) + t;
    run_txn("R7", 4'b0010, op, 1'b1, h, l, t, tb, 1'b0, lat, rb);
    chk(lat == n, treq, "read frame length", lat, n);
    chk(rb == tb, "R5", "byte valid with done", rb, tb);
    chk(gap == eff(l) + t, "R4", "clock-low cycles after release", gap, eff(l) + t);
    chk(hlog[11:0] == {op[7:0], 4'b0010}, "R2", "host bits of read frame",
        hlog[11:0], {op[7:0], 4'b0010});
    chk(rcnt == 8, "R5", "clocks while released", rcnt, 8);
  endtask

  task automatic t_write_keeps(input logic [7:0] held);
    int lat; logic [7:0] rb;
    run_txn("R9", 4'b0000, 16'hFFFF, 1'b0, 1, 1, 0, 8'h00, 1'b0, lat, rb);
    chk(rb == held, "R9", "rd_byte at write done", rb, held);
    chk(rd_byte == held, "R9", "rd_byte after write", rd_byte, held);
  endtask

  task automatic t_busy_ignore;
    int lat; logic [7:0] rb;
    run_txn("R8", 4'b1001, 16'h3C96, 1'b0, 2, 1, 0, 8'h00, 1'b1, lat, rb);
    chk(lat == 60, "R8", "length with start while busy", lat, 60);
    chk(hlog == {16'h3C96, 4'b1001}, "R8", "frame unchanged", hlog, {16'h3C96, 4'b1001});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write(4'b0000, 16'h0E5A, 2, 3);
    t_write(4'b1001, 16'h8001, 1, 1);
    t_write(4'b0110, 16'hA5C3, 0, 0);
    t_read(16'h00F0, 2, 2, 5, 8'hA5, "R4");
    t_read(16'h5A0F, 1, 2, 0, 8'h3C, "R10");
    t_write_keeps(8'h3C);
    t_busy_ignore();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule